// File: doc/BRIEF.md
# Plate Tilt Estimator

This block measures how far a number plate leans from the horizontal. It works on the binary image that the plate localisation stage leaves in a frame memory with rows 640 pixels wide. The caller supplies the plate region's upper-left corner, its width, its height and an inset. The block then probes two columns of the region: one lies the inset to the right of the left edge, and the other lies the inset to the left of the right edge. It walks down each column from the top row of the region until it meets the first set pixel.

The row at which each column first hits is that column's depth. The difference of the two depths, together with the horizontal distance between the two columns, gives the plate's tilt as a signed fixed-point ratio of run over rise. Later rotation and shear stages use this ratio directly, so no angle and no trigonometric function is ever evaluated. Both column probes share a single read port by taking alternate cycles. A zero depth difference is reported as a level plate. A column that holds no set pixel anywhere in the region is reported as an error.

A job starts with a one-cycle pulse on `start` while the block is idle. The block latches the region on that pulse, holds `busy` while it works, and pulses `done` when the results are ready. The results stay valid until the next job finishes.

Top module: `plate_tilt_est`

## Requirements
- R1: A probe of row r (counted from 1) reads address 640·(org_y + r − 1) + org_x + inset for the left column and 640·(org_y + r − 1) + org_x + span_w − inset for the right column. No read falls outside these two columns and rows 1..span_h of the region.
- R2: Both columns share one read port. Reads for the two columns take alternate cycles. A column gets no further reads once its hit is found, and `mem_rd` is low whenever the block is idle. Read data arrives one cycle after the request.
- R3: A column's depth is the row number (counted from 1) of its first set pixel. The number of reads that column receives equals its depth.
- R4: Let the depth difference be right depth minus left depth. When it is non-zero, `ratio` is ((span_w − 2·inset)·2^8) / |difference|, truncated toward zero, given the sign of the difference, and written in two's complement.
- R5: When the two depths are equal, `flat` is 1 and `ratio` is 0.
- R6: `dir` is 1 when the right depth is smaller than the left depth (negative difference) and 0 otherwise.
- R7: If a column finds no set pixel in rows 1..span_h, `err` is 1 and `ratio` and `flat` are 0. The column that missed has received exactly span_h reads.
- R8: `done` is a single-cycle pulse, and `busy` falls in the same cycle that `done` rises. A `start` pulse while `busy` is high is ignored and produces no second result.
- R9: After reset, `busy`, `done`, `mem_rd`, `ratio`, `flat`, `dir` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a job; the region is latched on this pulse |
| org_x | input | 10 | Left edge column of the region |
| org_y | input | 10 | Top edge row of the region |
| span_w | input | 10 | Region width |
| inset | input | 10 | Column inset from each side, at most span_w/2 (about span_w/4 is typical) |
| span_h | input | 10 | Region height, the search limit for each column, at least 1 |
| mem_rd | output | 1 | Frame memory read request |
| mem_addr | output | 19 | Frame memory read address |
| mem_rdata | input | 1 | Pixel value, valid the cycle after the request |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| ratio | output | 19 | Signed run-over-rise ratio with 8 fraction bits |
| flat | output | 1 | Depths equal, so no rotation is needed |
| dir | output | 1 | Tilt direction, 1 for a negative depth difference |
| err | output | 1 | A column had no set pixel in the region |

## Verification
The result of a job appears at `done`. That happens after one cycle to latch the region, at most about two cycles per row of the deeper column while the columns alternate, and then one step per quotient bit (18 steps) plus one cycle when the difference is non-zero. The bench therefore does not predict an exact cycle. The driver stamps each expected item with its start cycle and the region height. The monitor compares values only in the cycle where `done` is high, sampled on the falling clock edge, and it also checks that this cycle lies within 2·span_h + 28 cycles of the start. Read counts and address legality are collected by the bench's memory model between the start and the done pulse of each job.

// File: rtl/tilt_pkg.sv
package tilt_pkg;

    localparam int TILT_IMG_W   = 640;
    localparam int TILT_COORD_W = 10;
    localparam int TILT_ADDR_W  = 19;
    localparam int TILT_FRAC_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DIV
    } tilt_state_e;

    typedef struct packed {
        logic flat;
        logic dir;
        logic err;
    } tilt_flags_t;

endpackage

// File: rtl/tilt_col_scan.sv
module tilt_col_scan #(
    parameter int IMG_W   = 640,
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] span_w,
    input  logic [COORD_W-1:0] inset,
    input  logic [COORD_W-1:0] span_h,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rdata,
    output logic               both_hit,
    output logic               col_miss,
    output logic [COORD_W-1:0] depth_l,
    output logic [COORD_W-1:0] depth_r
);

    localparam int NCOL = 2;

    logic               active_q;
    logic               phase_q;
    logic               pend_v_q;
    logic               pend_col_q;
    logic [NCOL-1:0]    found_q;
    logic [COORD_W-1:0] row_q [NCOL];
    logic [COORD_W-1:0] col_x [NCOL];
    logic [NCOL-1:0]    hit_now;
    logic               miss_now;

    // Column positions and per-column hit detection on the returning read
    for (genvar i = 0; i < NCOL; i++) begin : g_col
        if (i == 0) begin : g_left
            assign col_x[i] = org_x + inset;
        end else begin : g_right
            assign col_x[i] = org_x + span_w - inset;
        end
        assign hit_now[i] = pend_v_q && (pend_col_q == 1'(i)) && mem_rdata;
    end

    assign miss_now = pend_v_q && !mem_rdata && (row_q[pend_col_q] == span_h);

    // Issue for the column owning this phase unless it already hit or a miss ends the job
    assign mem_rd   = active_q && !found_q[phase_q] && !miss_now;
    assign mem_addr = (ADDR_W'(org_y) + ADDR_W'(row_q[phase_q]) - ADDR_W'(1)) * ADDR_W'(IMG_W)
                    + ADDR_W'(col_x[phase_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            phase_q    <= 1'b0;
            pend_v_q   <= 1'b0;
            pend_col_q <= 1'b0;
            found_q    <= '0;
            row_q[0]   <= '0;
            row_q[1]   <= '0;
            depth_l    <= '0;
            depth_r    <= '0;
            both_hit   <= 1'b0;
            col_miss   <= 1'b0;
        end else begin
            both_hit <= 1'b0;
            col_miss <= 1'b0;
            if (!active_q) begin
                pend_v_q <= 1'b0;
                if (go) begin
                    active_q <= 1'b1;
                    phase_q  <= 1'b0;
                    found_q  <= '0;
                    row_q[0] <= COORD_W'(1);
                    row_q[1] <= COORD_W'(1);
                end
            end else begin
                phase_q    <= ~phase_q;
                pend_v_q   <= mem_rd;
                pend_col_q <= phase_q;
                if (pend_v_q) begin
                    if (mem_rdata) begin
                        found_q[pend_col_q] <= 1'b1;
                        if (pend_col_q) depth_r <= row_q[1];
                        else            depth_l <= row_q[0];
                    end else if (!miss_now) begin
                        row_q[pend_col_q] <= row_q[pend_col_q] + COORD_W'(1);
                    end
                end
                if (miss_now) begin
                    col_miss <= 1'b1;
                    active_q <= 1'b0;
                end else if ((found_q | hit_now) == {NCOL{1'b1}}) begin
                    both_hit <= 1'b1;
                    active_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tilt_udiv.sv
module tilt_udiv #(
    parameter int NUM_W = 18,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    // One restoring step: bring down the next numerator bit and try the divisor
    assign trial = {rem_q[DEN_W-1:0], sh_q[NUM_W-1]};
    assign fits  = trial >= {1'b0, den};
    assign quo   = sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            sh_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q <= '0;
                sh_q  <= num;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? (trial - {1'b0, den}) : trial;
                sh_q  <= {sh_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/plate_tilt_est.sv
module plate_tilt_est
    import tilt_pkg::*;
#(
    parameter int IMG_W   = TILT_IMG_W,
    parameter int COORD_W = TILT_COORD_W,
    parameter int ADDR_W  = TILT_ADDR_W,
    parameter int FRAC_W  = TILT_FRAC_W,
    localparam int NUM_W   = COORD_W + FRAC_W,
    localparam int RATIO_W = NUM_W + 1,
    localparam int DD_W    = COORD_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] span_w,
    input  logic [COORD_W-1:0] inset,
    input  logic [COORD_W-1:0] span_h,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [RATIO_W-1:0] ratio,
    output logic               flat,
    output logic               dir,
    output logic               err
);

    typedef struct packed {
        logic [COORD_W-1:0] ox;
        logic [COORD_W-1:0] oy;
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] ins;
        logic [COORD_W-1:0] h;
    } region_t;

    tilt_state_e        state_q;
    region_t            cfg_q;
    tilt_flags_t        flags_q;
    logic               scan_go_q;
    logic               div_go_q;
    logic [COORD_W-1:0] den_q;

    logic               hit_both;
    logic               col_miss;
    logic [COORD_W-1:0] depth_l;
    logic [COORD_W-1:0] depth_r;
    logic               div_fin;
    logic [NUM_W-1:0]   quo;

    logic [DD_W-1:0]    dd;
    logic [DD_W-1:0]    dd_neg;
    logic [COORD_W-1:0] dd_mag;
    logic [COORD_W-1:0] run_len;
    logic [NUM_W-1:0]   num;
    logic [RATIO_W-1:0] quo_ext;
    logic [RATIO_W-1:0] ratio_nx;

    // Depth difference, right minus left, and its magnitude
    assign dd      = {1'b0, depth_r} - {1'b0, depth_l};
    assign dd_neg  = -dd;
    assign dd_mag  = dd[DD_W-1] ? dd_neg[COORD_W-1:0] : dd[COORD_W-1:0];

    // Horizontal run between the probed columns, scaled to fixed point
    assign run_len  = cfg_q.w - {cfg_q.ins[COORD_W-2:0], 1'b0};
    assign num      = {run_len, {FRAC_W{1'b0}}};
    assign quo_ext  = {1'b0, quo};
    assign ratio_nx = flags_q.dir ? -quo_ext : quo_ext;

    assign busy = (state_q != ST_IDLE);
    assign flat = flags_q.flat;
    assign dir  = flags_q.dir;
    assign err  = flags_q.err;

    tilt_col_scan #(
        .IMG_W   (IMG_W),
        .COORD_W (COORD_W),
        .ADDR_W  (ADDR_W)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .go        (scan_go_q),
        .org_x     (cfg_q.ox),
        .org_y     (cfg_q.oy),
        .span_w    (cfg_q.w),
        .inset     (cfg_q.ins),
        .span_h    (cfg_q.h),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .both_hit  (hit_both),
        .col_miss  (col_miss),
        .depth_l   (depth_l),
        .depth_r   (depth_r)
    );

    tilt_udiv #(
        .NUM_W (NUM_W),
        .DEN_W (COORD_W)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go_q),
        .num (num),
        .den (den_q),
        .fin (div_fin),
        .quo (quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            flags_q   <= '0;
            scan_go_q <= 1'b0;
            div_go_q  <= 1'b0;
            den_q     <= '0;
            ratio     <= '0;
            done      <= 1'b0;
        end else begin
            done      <= 1'b0;
            scan_go_q <= 1'b0;
            div_go_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q     <= '{ox: org_x, oy: org_y, w: span_w, ins: inset, h: span_h};
                        scan_go_q <= 1'b1;
                        state_q   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (col_miss) begin
                        flags_q <= '{flat: 1'b0, dir: 1'b0, err: 1'b1};
                        ratio   <= '0;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (hit_both) begin
                        if (dd == '0) begin
                            flags_q <= '{flat: 1'b1, dir: 1'b0, err: 1'b0};
                            ratio   <= '0;
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            flags_q  <= '{flat: 1'b0, dir: dd[DD_W-1], err: 1'b0};
                            den_q    <= dd_mag;
                            div_go_q <= 1'b1;
                            state_q  <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        ratio   <= ratio_nx;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/plate_tilt_est_chk.sv
module plate_tilt_est_chk #(
    parameter int RATIO_W = 19
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               mem_rd,
    input logic               busy,
    input logic               done,
    input logic [RATIO_W-1:0] ratio,
    input logic               flat,
    input logic               dir,
    input logic               err
);

    // R9: the cycle after reset is quiet
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !mem_rd));

    // R2: reads only while a job runs
    a_r2_read_when_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: busy drops only together with done
    a_r8_fall_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: a running job is not disturbed by start
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R5: a level plate reports a zero ratio
    a_r5_flat_zero: assert property (@(posedge clk) disable iff (rst)
        (done && flat) |-> (ratio == '0 && !err));

    // R7: a miss reports nothing else
    a_r7_err_clean: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (ratio == '0 && !flat));

    // R6: direction flag agrees with the ratio sign
    a_r6_dir_sign: assert property (@(posedge clk) disable iff (rst)
        (done && !err && !flat && ratio != '0) |-> (ratio[RATIO_W-1] == dir));

endmodule

bind plate_tilt_est plate_tilt_est_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mem_rd (mem_rd),
    .busy   (busy),
    .done   (done),
    .ratio  (ratio),
    .flat   (flat),
    .dir    (dir),
    .err    (err)
);

// File: tb/plate_tilt_est_bench.sv
module plate_tilt_est_bench;

    localparam int IMG_W   = 640;
    localparam int RATIO_W = 19;
    localparam int LAT_PAD = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [9:0]  org_x = '0, org_y = '0, span_w = '0, inset = '0, span_h = '0;
    logic        mem_rd;
    logic [18:0] mem_addr;
    logic        mem_rdata = 1'b0;
    logic        busy, done, flat, dir, err;
    logic [RATIO_W-1:0] ratio;

    always #5 clk = ~clk;

    plate_tilt_est u_plate_tilt_est (
        .clk(clk), .rst(rst), .start(start),
        .org_x(org_x), .org_y(org_y), .span_w(span_w), .inset(inset), .span_h(span_h),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ratio(ratio), .flat(flat), .dir(dir), .err(err)
    );

    typedef struct {
        int ratio; bit flat; bit dir; bit err;
        int ca; int cb; int t0; int h;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0, cyc = 0, n_done = 0, n_issued = 0;

    // Scene for the current job
    int cur_xa, cur_xb, cur_y0, cur_h, cur_ta, cur_tb;
    int cnt_a = 0, cnt_b = 0, bad_addr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic pix(input int x, input int y);
        int row;
        if (y < cur_y0) return 1'b1;
        if (x != cur_xa && x != cur_xb) return 1'b1;
        row = y - cur_y0 + 1;
        if (x == cur_xa) return (cur_ta != 0) && (row >= cur_ta);
        return (cur_tb != 0) && (row >= cur_tb);
    endfunction

    // Frame memory model: one-cycle read latency, counts reads per column
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_rd) begin
            int x, y;
            x = int'(mem_addr) % IMG_W;
            y = int'(mem_addr) / IMG_W;
            mem_rdata <= pix(x, y);
            if (x == cur_xa) cnt_a = cnt_a + 1;
            else if (x == cur_xb) cnt_b = cnt_b + 1;
            else bad_addr = bad_addr + 1;
            if (y < cur_y0 || y >= cur_y0 + cur_h) bad_addr = bad_addr + 1;
        end
    end

    // Driver: computes the expected item from the requirements and starts a job
    task automatic run_job(input int ox, input int oy, input int w, input int ins, input int h,
                           input int ta, input int tb, input bit poke);
        exp_t e;
        int dd, q;
        dd = tb - ta;
        e.err = (ta == 0) || (tb == 0);
        e.flat = !e.err && (dd == 0);
        e.dir = !e.err && (dd < 0);
        e.ratio = 0;
        if (!e.err && dd != 0) begin
            q = ((w - 2 * ins) * 256) / (dd < 0 ? -dd : dd);
            e.ratio = (dd < 0) ? -q : q;
        end
        e.ca = (ta != 0) ? ta : h;
        e.cb = (tb != 0) ? tb : h;
        if (ta == 0 && tb == 0) begin e.ca = -1; e.cb = -1; end
        e.h = h;
        @(negedge clk);
        cur_xa = ox + ins; cur_xb = ox + w - ins; cur_y0 = oy; cur_h = h;
        cur_ta = ta; cur_tb = tb;
        cnt_a = 0; cnt_b = 0; bad_addr = 0;
        org_x = 10'(ox); org_y = 10'(oy); span_w = 10'(w); inset = 10'(ins); span_h = 10'(h);
        e.t0 = cyc;
        exp_q.push_back(e);
        n_issued++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        org_x = 10'd7; span_w = 10'd3;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops the expected item on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'($signed(ratio)) == e.ratio, "R4 ratio", int'($signed(ratio)), e.ratio);
                chk(flat == e.flat, "R5 flat", int'(flat), int'(e.flat));
                chk(dir == e.dir, "R6 dir", int'(dir), int'(e.dir));
                chk(err == e.err, "R7 err", int'(err), int'(e.err));
                chk(bad_addr == 0, "R1 address outside probed columns", bad_addr, 0);
                if (e.ca >= 0) chk(cnt_a == e.ca, "R3 left column reads", cnt_a, e.ca);
                if (e.cb >= 0) chk(cnt_b == e.cb, "R3 right column reads", cnt_b, e.cb);
                chk(cyc - e.t0 <= 2 * e.h + LAT_PAD, "R8 latency bound", cyc - e.t0, 2 * e.h + LAT_PAD);
                chk(!busy, "R8 busy low with done", int'(busy), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cur_xa = -1; cur_xb = -1; cur_y0 = 0; cur_h = 0; cur_ta = 0; cur_tb = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(!busy, "R9 busy after reset", int'(busy), 0);
        chk(!done, "R9 done after reset", int'(done), 0);
        chk(!mem_rd, "R9 mem_rd after reset", int'(mem_rd), 0);
        chk(ratio == '0 && !flat && !dir && !err, "R9 results after reset", int'(ratio), 0);

        run_job(100, 50, 80, 20, 30, 5, 9, 1'b0);   // R4 positive tilt: 2560
        run_job(100, 50, 80, 20, 30, 12, 3, 1'b0);  // R4 R6 negative tilt: -1137
        run_job(200, 100, 120, 30, 25, 7, 7, 1'b0); // R5 level plate
        run_job(300, 10, 100, 25, 12, 0, 4, 1'b0);  // R7 left column misses
        run_job(300, 10, 100, 25, 12, 3, 0, 1'b0);  // R7 right column misses
        run_job(150, 200, 200, 50, 20, 1, 20, 1'b0); // R3 hit on first and last rows: 1347
        run_job(0, 0, 64, 16, 16, 16, 1, 1'b0);     // R1 R6 region at frame origin: -546
        run_job(500, 300, 96, 24, 40, 10, 14, 1'b1); // R8 start while busy ignored: 3072
        run_job(10, 5, 40, 20, 8, 0, 0, 1'b0);      // R7 both columns miss, zero run

        chk(n_done == n_issued, "R8 done count", n_done, n_issued);
        chk(!mem_rd, "R2 no reads while idle", int'(mem_rd), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule